// File: doc/BRIEF.md
# Replayable FIFO with Half-Occupancy Flag

This block is a single-clock first-in/first-out buffer of 9-bit words whose depth is a parameter (256, 512 or 1024 entries). The user supplies no addresses: a write strobe stores the word on the input bus at the next free slot, and a read strobe fetches the oldest stored word. Both slot indices are ring counters that wrap at the array boundary. Three active-low status flags report empty, full and more-than-half occupancy. All three are registered and are derived from a single occupancy counter.

A rewind strobe sends the read index back to slot zero and leaves the write index where it is. The words written since reset can then be read again from the start. This replay is meant for bursts shorter than the array: for example, a frame that must be re-sent after the far end rejected it. A rewind requested in the same cycle as a read or write is refused, and a sticky error bit is raised. Read data is registered and is qualified by a valid strobe one cycle after the accepted read, so the block needs no tri-state outputs.

Top module: `rt_fifo`

## Requirements
- R1: While rst_n is low at a clock edge, the block takes its reset state: empty_n=0, full_n=1, half_n=1, rd_valid=0, rt_err=0. Both indices go to slot zero.
- R2: Reads return words in the order they were written. After a read accepted at edge k, rd_valid is 1 after edge k and rd_data holds the word; otherwise rd_valid is 0.
- R3: A write strobe while full_n is 0 is ignored. The word is never stored and the write index does not move.
- R4: A read strobe while empty_n is 0 is ignored. rd_valid stays 0 and the read index does not move.
- R5: Starting from reset with no reads, full_n goes to 0 after exactly DEPTH accepted writes, and not earlier.
- R6: empty_n goes to 0 after the read that takes the last stored word. It returns to 1 after the next accepted write. All flags change at the clock edge that accepts the operation.
- R7: half_n is 0 exactly when occupancy exceeds DEPTH/2. It falls on the write that raises occupancy to DEPTH/2+1 and rises on the read that brings it back to DEPTH/2.
- R8: A rewind strobe (rt_req=1 with wr_req=0 and rd_req=0) sets the read index to slot zero and leaves the write index unchanged. Occupancy becomes the write index, or DEPTH when the write index is at slot zero after having wrapped at least once. All flags follow the new occupancy.
- R9: A rewind strobe in the same cycle as wr_req or rd_req is ignored, while the read or write itself proceeds. rt_err becomes 1 and stays 1 until reset.
- R10: An accepted read and an accepted write in the same cycle, at occupancy between 1 and DEPTH-1, leave occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_req | input | 1 | Write strobe, one word per cycle |
| wr_data | input | 9 | Word to store |
| rd_req | input | 1 | Read strobe, one word per cycle |
| rt_req | input | 1 | Rewind strobe for replay |
| rd_data | output | 9 | Registered read word |
| rd_valid | output | 1 | rd_data holds a word read at the previous edge |
| empty_n | output | 1 | Low when nothing is stored |
| full_n | output | 1 | Low when DEPTH words are stored |
| half_n | output | 1 | Low when more than DEPTH/2 words are stored |
| rt_err | output | 1 | Sticky: rewind requested together with a read or write |

## Verification
The assertions check the following on every cycle: the refusal of writes while full and of reads while empty, the valid strobe that follows each accepted read, empty deasserting after any accepted write, consistency between the flags, and the stickiness of the rewind error. Only the bench scenarios can show word ordering, the exact write count at which full and half-occupancy appear, replay from slot zero after a rewind (including the wrapped-full case), and unchanged occupancy under simultaneous read and write. The bench checks these against a reference model running under directed corner cases and seeded random traffic.

// File: rtl/rt_fifo_pkg.sv
// Package rt_fifo_pkg
// Shared word width and word type for the replayable FIFO.
package rt_fifo_pkg;
    localparam int WORD_W = 9;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/rt_fifo_mem.sv
// Module rt_fifo_mem
// Storage array with one write port and one registered read port.
// Assumes the control logic never reads and writes the same slot in one cycle.
module rt_fifo_mem
    import rt_fifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);
    word_t store [DEPTH];

    // Write port: store the incoming word at the write slot.
    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    // Read port: capture the addressed word on an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= store[raddr];
    end
endmodule

// File: rtl/rt_fifo_ptr.sv
// Module rt_fifo_ptr
// Ring index over DEPTH slots with an advance and a rewind-to-zero input.
// Rewind has priority over advance. wrap_o pulses when an advance leaves the last slot.
module rt_fifo_ptr #(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          rewind,
    output logic [AW-1:0] ptr,
    output logic          wrap_o
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic last_slot;

    // Detect the wrap point of the ring.
    always_comb begin
        last_slot = (ptr == LAST);
        wrap_o    = adv && last_slot && !rewind;
    end

    // Index register: rewind, advance with wrap, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)         ptr <= '0;
        else if (rewind)    ptr <= '0;
        else if (adv)       ptr <= last_slot ? '0 : ptr + 1'b1;
    end
endmodule

// File: rtl/rt_fifo_flags.sv
// Module rt_fifo_flags
// Occupancy counter and registered active-low status flags.
// On a rewind, occupancy is rebuilt from the write index. When that index is zero
// and the ring has wrapped, the whole array counts as stored.
// Assumes rd_acc only when not empty, wr_acc only when not full, and rt_acc exclusive of both.
module rt_fifo_flags #(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_acc,
    input  logic          rd_acc,
    input  logic          rt_acc,
    input  logic [AW-1:0] wr_ptr,
    input  logic          wr_wrap,
    output logic          empty_n,
    output logic          full_n,
    output logic          half_n
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

    logic [CW-1:0] count_q, count_nx;
    logic          lapped_q;

    // Next occupancy from the accepted operations of this cycle.
    always_comb begin
        count_nx = count_q;
        if (rt_acc) begin
            if (lapped_q && (wr_ptr == '0)) count_nx = FULL_CNT;
            else                            count_nx = {1'b0, wr_ptr};
        end else if (wr_acc && !rd_acc) begin
            count_nx = count_q + 1'b1;
        end else if (rd_acc && !wr_acc) begin
            count_nx = count_q - 1'b1;
        end
    end

    // Sticky record that the write index has completed at least one lap.
    always_ff @(posedge clk) begin
        if (!rst_n)       lapped_q <= 1'b0;
        else if (wr_wrap) lapped_q <= 1'b1;
    end

    // Occupancy and flags registered together from the next count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            empty_n <= 1'b0;
            full_n  <= 1'b1;
            half_n  <= 1'b1;
        end else begin
            count_q <= count_nx;
            empty_n <= (count_nx != '0);
            full_n  <= (count_nx != FULL_CNT);
            half_n  <= !(count_nx > HALF_CNT);
        end
    end
endmodule

// File: rtl/rt_fifo.sv
// Module rt_fifo
// Single-clock FIFO of 9-bit words with replay from slot zero and a half-occupancy flag.
// Strobes are one word per clock. Read data is registered and qualified by rd_valid.
// Assumes DEPTH is a power of two (256, 512 or 1024).
module rt_fifo
    import rt_fifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_req,
    input  logic              rt_req,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              empty_n,
    output logic              full_n,
    output logic              half_n,
    output logic              rt_err
);
    logic          wr_acc, rd_acc, rt_acc, rt_clash;
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          wr_wrap, rd_wrap_unused;

    // Accept decode: the flags gate the strobes, and a rewind needs a quiet cycle.
    always_comb begin
        wr_acc   = wr_req && full_n;
        rd_acc   = rd_req && empty_n;
        rt_acc   = rt_req && !wr_req && !rd_req;
        rt_clash = rt_req && (wr_req || rd_req);
    end

    rt_fifo_ptr #(.DEPTH(DEPTH)) u_wptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (wr_acc),
        .rewind (1'b0),
        .ptr    (wr_ptr),
        .wrap_o (wr_wrap)
    );

    rt_fifo_ptr #(.DEPTH(DEPTH)) u_rptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (rd_acc),
        .rewind (rt_acc),
        .ptr    (rd_ptr),
        .wrap_o (rd_wrap_unused)
    );

    rt_fifo_mem #(.DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_acc),
        .waddr (wr_ptr),
        .wdata (wr_data),
        .re    (rd_acc),
        .raddr (rd_ptr),
        .rdata (rd_data)
    );

    rt_fifo_flags #(.DEPTH(DEPTH)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_acc  (wr_acc),
        .rd_acc  (rd_acc),
        .rt_acc  (rt_acc),
        .wr_ptr  (wr_ptr),
        .wr_wrap (wr_wrap),
        .empty_n (empty_n),
        .full_n  (full_n),
        .half_n  (half_n)
    );

    // Valid strobe for the registered read word.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid <= 1'b0;
        else        rd_valid <= rd_acc;
    end

    // Sticky error for a rewind that collided with traffic.
    always_ff @(posedge clk) begin
        if (!rst_n)        rt_err <= 1'b0;
        else if (rt_clash) rt_err <= 1'b1;
    end
endmodule

// File: rtl/rt_fifo_chk.sv
// Module rt_fifo_chk
// Port-level temporal checks for rt_fifo, attached by bind below.
module rt_fifo_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_req,
    input logic rd_req,
    input logic rt_req,
    input logic rd_valid,
    input logic empty_n,
    input logic full_n,
    input logic half_n,
    input logic rt_err
);
    // R1: the first cycle out of reset shows the reset flags
    a_r1_reset_flags: assert property (@(posedge clk)
        $rose(rst_n) |-> (!empty_n && full_n && half_n && !rd_valid && !rt_err));

    // R3: a write while full is refused, so full remains
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && !rd_req && !rt_req) |=> !full_n);

    // R4: a read while empty is refused: no valid and still empty
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && !wr_req && !rt_req) |=> (!empty_n && !rd_valid));

    // R2: an accepted read yields valid data one cycle later
    a_r2_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && empty_n) |=> rd_valid);

    // R2: no valid without an accepted read
    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && empty_n) |=> !rd_valid);

    // R6: any accepted write leaves the FIFO non-empty
    a_r6_write_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && full_n) |=> empty_n);

    // R7: full implies more than half occupied and not empty
    a_r7_flag_order: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |-> (!half_n && empty_n));

    // R9: the rewind error is sticky
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rt_err |=> rt_err);

    // R9: a colliding rewind raises the error
    a_r9_err_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_req && (wr_req || rd_req)) |=> rt_err);
endmodule

bind rt_fifo rt_fifo_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_req   (wr_req),
    .rd_req   (rd_req),
    .rt_req   (rt_req),
    .rd_valid (rd_valid),
    .empty_n  (empty_n),
    .full_n   (full_n),
    .half_n   (half_n),
    .rt_err   (rt_err)
);

// File: tb/tb_rt_fifo.sv
// Bench for rt_fifo: directed corner cases plus seeded random traffic,
// compared every cycle against a reference model built from the requirements.
module tb_rt_fifo;
    localparam int D = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_req = 1'b0, rd_req = 1'b0, rt_req = 1'b0;
    logic [8:0] wr_data = '0;
    logic [8:0] rd_data;
    logic       rd_valid, empty_n, full_n, half_n, rt_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    rt_fifo #(.DEPTH(D)) dut (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_data(wr_data),
        .rd_req(rd_req), .rt_req(rt_req), .rd_data(rd_data), .rd_valid(rd_valid),
        .empty_n(empty_n), .full_n(full_n), .half_n(half_n), .rt_err(rt_err)
    );

    always #5 clk = ~clk;

    // Reference model state
    logic [8:0] m_mem [D];
    int         m_wp, m_rp, m_cnt;
    bit         m_lap, m_err, m_valid;
    logic [8:0] m_data;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_empty_n(); return m_cnt != 0; endfunction
    function automatic bit exp_full_n();  return m_cnt != D; endfunction
    function automatic bit exp_half_n();  return !(m_cnt > D/2); endfunction

    task automatic do_reset();
        rst_n = 1'b0; wr_req = 0; rd_req = 0; rt_req = 0;
        repeat (3) @(negedge clk);
        m_wp = 0; m_rp = 0; m_cnt = 0; m_lap = 0; m_err = 0; m_valid = 0;
        rst_n = 1'b1;
        chk(empty_n == 1'b0, "R1 empty_n", empty_n, 0);
        chk(full_n  == 1'b1, "R1 full_n", full_n, 1);
        chk(half_n  == 1'b1, "R1 half_n", half_n, 1);
        chk(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
        chk(rt_err  == 1'b0, "R1 rt_err", rt_err, 0);
    endtask

    // One clock: drive at the falling edge, update the model, check at the next falling edge.
    task automatic step(input bit w, input bit r, input bit t, input logic [8:0] d);
        bit wa, ra, ta;
        wr_req = w; rd_req = r; rt_req = t; wr_data = d;
        wa = w && (m_cnt != D);
        ra = r && (m_cnt != 0);
        ta = t && !w && !r;
        if (t && (w || r)) m_err = 1;
        m_valid = ra;
        if (ra) begin
            m_data = m_mem[m_rp];
            m_rp = (m_rp + 1) % D;
        end
        if (wa) begin
            m_mem[m_wp] = d;
            if (m_wp == D - 1) m_lap = 1;
            m_wp = (m_wp + 1) % D;
        end
        if (ta) begin
            m_rp = 0;
            m_cnt = (m_wp == 0 && m_lap) ? D : m_wp;
        end else begin
            m_cnt = m_cnt + int'(wa) - int'(ra);
        end
        @(negedge clk);
        wr_req = 0; rd_req = 0; rt_req = 0;
        chk(empty_n == exp_empty_n(), "R6 empty_n", empty_n, exp_empty_n());
        chk(full_n  == exp_full_n(),  "R5 full_n", full_n, exp_full_n());
        chk(half_n  == exp_half_n(),  "R7 half_n", half_n, exp_half_n());
        chk(rd_valid == m_valid,      "R4 rd_valid", rd_valid, m_valid);
        if (m_valid) chk(rd_data == m_data, "R2 rd_data", rd_data, m_data);
        chk(rt_err == m_err,          "R9 rt_err", rt_err, m_err);
    endtask

    // Watchdog: a hung run is a failure.
    initial begin
        #2_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed_init;
        seed_init = $urandom(32'h5EED);
        @(negedge clk);
        do_reset();

        // R4: read on empty is ignored
        step(0, 1, 0, 0);
        chk(rd_valid == 0 && empty_n == 0, "R4 read on empty", {rd_valid, empty_n}, 0);

        // R5 and R7: fill from reset with no reads
        for (int i = 0; i < D; i++) begin
            step(1, 0, 0, 9'(i & 8'hFF));
            if (i == D/2 - 1) chk(half_n == 1, "R7 at half", half_n, 1);
            if (i == D/2)     chk(half_n == 0, "R7 above half", half_n, 0);
            if (i == D - 2)   chk(full_n == 1, "R5 one short", full_n, 1);
        end
        chk(full_n == 0, "R5 full after DEPTH writes", full_n, 0);

        // R3: write while full is dropped
        step(1, 0, 0, 9'h1AA);
        chk(full_n == 0, "R3 still full", full_n, 0);
        for (int i = 0; i < D; i++) begin
            step(0, 1, 0, 0);
            chk(rd_data != 9'h1AA && rd_data == 9'(i & 8'hFF), "R3 stored order", rd_data, i & 8'hFF);
        end
        chk(empty_n == 0, "R6 empty after last read", empty_n, 0);
        step(1, 0, 0, 9'h033);
        chk(empty_n == 1, "R6 empty clears on write", empty_n, 1);
        step(0, 1, 0, 0);

        // R10: simultaneous read and write just above half
        for (int i = 0; i < D/2 + 1; i++) step(1, 0, 0, 9'(i + 9'h100));
        chk(half_n == 0, "R10 setup above half", half_n, 0);
        for (int i = 0; i < 5; i++) step(1, 1, 0, 9'(i + 9'h180));
        chk(half_n == 0 && full_n == 1, "R10 count held", {half_n, full_n}, 1);
        step(0, 1, 0, 0);
        chk(half_n == 1, "R10 one read drops to half", half_n, 1);

        // R8: replay from slot zero
        do_reset();
        for (int i = 0; i < 10; i++) step(1, 0, 0, 9'(9'h0A0 + i));
        for (int i = 0; i < 4; i++) step(0, 1, 0, 0);
        step(0, 0, 1, 0);
        chk(empty_n == 1 && rt_err == 0, "R8 rewind accepted", {empty_n, rt_err}, 2);
        for (int i = 0; i < 10; i++) begin
            step(0, 1, 0, 0);
            chk(rd_data == 9'(9'h0A0 + i), "R8 replay order", rd_data, 9'h0A0 + i);
        end
        chk(empty_n == 0, "R8 empty after replay", empty_n, 0);

        // R9: rewind colliding with a write is ignored
        step(1, 0, 1, 9'h055);
        chk(rt_err == 1, "R9 error raised", rt_err, 1);
        step(0, 1, 0, 0);
        chk(rd_data == 9'h055, "R9 rewind ignored", rd_data, 9'h055);
        step(0, 0, 0, 0);
        chk(rt_err == 1, "R9 error sticky", rt_err, 1);
        do_reset();

        // R8: rewind after a full lap restores the whole array
        for (int i = 0; i < D; i++) step(1, 0, 0, 9'(i ^ 9'h0F0));
        for (int i = 0; i < 3; i++) step(0, 1, 0, 0);
        step(0, 0, 1, 0);
        chk(full_n == 0, "R8 lapped rewind full", full_n, 0);
        step(0, 1, 0, 0);
        chk(rd_data == 9'h0F0, "R8 lapped replay first", rd_data, 9'h0F0);

        // Random traffic in write-heavy, read-heavy and balanced phases
        for (int ph = 0; ph < 3; ph++) begin
            for (int n = 0; n < 1500; n++) begin
                bit w, r, t;
                int p = (ph == 0) ? 75 : (ph == 1) ? 25 : 50;
                w = ($urandom % 100) < p;
                r = ($urandom % 100) < (100 - p);
                t = ($urandom % 40) == 0;
                if (t && ($urandom % 4) != 0) begin w = 0; r = 0; end
                step(w, r, t, 9'($urandom));
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule